// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block guesses whether a conditional branch will be taken, for an in-order fetch stage, and learns from outcomes once branches resolve. A two-bit mode input selects the policy at run time. The first policy is a fixed rule: a branch that jumps to a lower address is treated as a loop and guessed taken, and a branch that jumps forward is guessed not-taken. The second policy is a table of single-bit entries that remembers the last outcome. The third policy is a table of two-bit saturating counters that needs two wrong outcomes in a row before its guess flips.

The fetch side presents the branch PC and its target. It receives a combinational taken/not-taken guess and the address to fetch next. The resolve side presents the branch PC, its target, the actual outcome and the guess that was made for it at fetch. The block then updates the table entry, reports a mispredict pulse and advances two running counters. The ratio of the correct counter to the total counter is the prediction accuracy. Both table policies share one storage array, so a change of mode keeps what has been learned.

Top module: `branch_predictor`

## Requirements
- R1: After reset the total counter, the correct counter and the mispredict output are zero. Every table entry holds binary 01 (weakly not-taken), so fetch guesses not-taken for every PC in both table modes.
- R2: The next fetch address is the fetch target when the guess is taken, and fetch PC + 4 otherwise. The resolved next address is the resolve target when the outcome is taken, and resolve PC + 4 otherwise.
- R3: In mode 0 (static), the guess is taken exactly when the target is unsigned-lower than the PC. A target equal to the PC is guessed not-taken. Resolves made in mode 0 leave the table unchanged.
- R4: The table index is PC bits [ADDR_W-1:2] modulo ENTRIES. With the default of 64 entries, two PCs that differ by 256 share an entry.
- R5: In mode 1 (one-bit), a resolve overwrites the entry with its outcome: 10 if taken, 01 if not-taken. Fetch then guesses that same outcome for the entry.
- R6: In modes 2 and 3 (two-bit), the entry is a counter over 00..11. The guess is taken for 10 and 11. A taken outcome adds one and stops at 11. A not-taken outcome subtracts one and stops at 00.
- R7: In two-bit mode, a single not-taken outcome at 11 leaves the entry at 10, and the guess stays taken.
- R8: Each valid resolve adds one to the total counter. The correct counter adds one only when the carried guess equals the actual outcome. Neither counter changes without a valid resolve.
- R9: The mispredict output is high for exactly the one cycle after a valid resolve whose carried guess differs from its outcome. It is low otherwise.
- R10: When fetch and resolve address the same entry in one cycle, fetch sees the value from before the update. The new value is visible from the next cycle.
- R11: Changing the mode does not alter the table. An entry written in one-bit mode is read as a counter value in two-bit mode, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 0 static, 1 one-bit, 2 or 3 two-bit |
| fetch_pc | input | ADDR_W | Address of the branch being fetched |
| fetch_target | input | ADDR_W | Target of the branch being fetched |
| pred_taken | output | 1 | Guess for the fetched branch |
| next_pc | output | ADDR_W | Address to fetch next |
| rsv_valid | input | 1 | A resolved branch is presented this cycle |
| rsv_pc | input | ADDR_W | Address of the resolved branch |
| rsv_target | input | ADDR_W | Target of the resolved branch |
| rsv_taken | input | 1 | Actual outcome of the resolved branch |
| rsv_pred | input | 1 | Guess that was made for the resolved branch at fetch |
| rsv_next_pc | output | ADDR_W | Correct-path address for the resolved branch |
| mispredict | output | 1 | One-cycle pulse after a wrongly guessed resolve |
| total_cnt | output | CNT_W | Number of valid resolves |
| correct_cnt | output | CNT_W | Number of correctly guessed resolves |

## Verification
The assertions assume that fetch PCs and targets are word aligned. They also assume that the counters never reach their wrap point during a run, because the increment properties compare against the previous value plus one. The stimulus uses only addresses that are multiples of 4 and stays far below 2^32 resolves. The carried guess on the resolve side is driven freely, so correct, wrong and mixed sequences are all covered. Mode codes, including the second two-bit code 3, are switched at random between cycles.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef enum logic [1:0] {
      MODE_STATIC  = 2'd0,
      MODE_ONEBIT  = 2'd1,
      MODE_TWOBIT  = 2'd2,
      MODE_TWOBIT3 = 2'd3
   } bp_mode_e;

   typedef logic [1:0] bp_state_t;

   localparam bp_state_t ST_STRONG_NT = 2'b00;
   localparam bp_state_t ST_WEAK_NT   = 2'b01;
   localparam bp_state_t ST_WEAK_T    = 2'b10;
   localparam bp_state_t ST_STRONG_T  = 2'b11;

   function automatic bp_state_t bp_next_state(input bp_mode_e m, input bp_state_t s,
                                               input logic taken);
      bp_state_t r;
      r = s;
      if (m == MODE_ONEBIT) begin
         r = taken ? ST_WEAK_T : ST_WEAK_NT;
      end else if (m == MODE_TWOBIT || m == MODE_TWOBIT3) begin
         if (taken && s != ST_STRONG_T) r = s + 2'd1;
         else if (!taken && s != ST_STRONG_NT) r = s - 2'd1;
      end
      return r;
   endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx
);
   localparam bit POW2 = ((1 << IDX_W) == ENTRIES);

   generate
      if (POW2) begin : g_slice
         assign idx = pc[IDX_W+1:2];
      end else begin : g_modulo
         localparam logic [ADDR_W-3:0] ENT_L = (ADDR_W-2)'(ENTRIES);
         logic [ADDR_W-3:0] word_no;
         logic [ADDR_W-3:0] rem;
         assign word_no = pc[ADDR_W-1:2];
         assign rem     = word_no % ENT_L;
         assign idx     = rem[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/bp_table.sv
module bp_table
   import bp_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output bp_state_t        rd_state,
   input  logic             wr_en,
   input  bp_mode_e         wr_mode,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   bp_state_t cells [ENTRIES];
   bp_state_t wr_next;

   assign rd_state = cells[rd_idx];
   assign wr_next  = bp_next_state(wr_mode, cells[wr_idx], wr_taken);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cells[i] <= ST_WEAK_NT;
      end else if (wr_en) begin
         cells[wr_idx] <= wr_next;
      end
   end
endmodule

// File: rtl/bp_stats.sv
module bp_stats #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_valid,
   input  logic             hit_right,
   output logic             miss_pulse,
   output logic [CNT_W-1:0] total_q,
   output logic [CNT_W-1:0] right_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q    <= '0;
         right_q    <= '0;
         miss_pulse <= 1'b0;
      end else begin
         miss_pulse <= hit_valid && !hit_right;
         if (hit_valid) begin
            total_q <= total_q + 1'b1;
            if (hit_right) right_q <= right_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
   import bp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 64,
   parameter int CNT_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic [ADDR_W-1:0] fetch_target,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] next_pc,
   input  logic              rsv_valid,
   input  logic [ADDR_W-1:0] rsv_pc,
   input  logic [ADDR_W-1:0] rsv_target,
   input  logic              rsv_taken,
   input  logic              rsv_pred,
   output logic [ADDR_W-1:0] rsv_next_pc,
   output logic              mispredict,
   output logic [CNT_W-1:0]  total_cnt,
   output logic [CNT_W-1:0]  correct_cnt
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("branch_predictor: ENTRIES must be at least 2");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_addr
         $error("branch_predictor: ADDR_W too narrow for ENTRIES");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("branch_predictor: CNT_W must be positive");
      end
   endgenerate

   bp_mode_e         cur_mode;
   logic [IDX_W-1:0] f_idx;
   logic [IDX_W-1:0] r_idx;
   bp_state_t        f_state;
   logic             dyn_guess;
   logic             static_guess;

   assign cur_mode = bp_mode_e'(mode);

   bp_index #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_fidx (.pc(fetch_pc), .idx(f_idx));
   bp_index #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_ridx (.pc(rsv_pc),   .idx(r_idx));

   bp_table #(.ENTRIES(ENTRIES)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (f_idx),
      .rd_state (f_state),
      .wr_en    (rsv_valid && cur_mode != MODE_STATIC),
      .wr_mode  (cur_mode),
      .wr_idx   (r_idx),
      .wr_taken (rsv_taken)
   );

   assign dyn_guess    = f_state[1];
   assign static_guess = (fetch_target < fetch_pc);

   always_comb begin
      unique case (cur_mode)
         MODE_STATIC: pred_taken = static_guess;
         default:     pred_taken = dyn_guess;
      endcase
   end

   assign next_pc     = pred_taken ? fetch_target : fetch_pc + STEP;
   assign rsv_next_pc = rsv_taken  ? rsv_target   : rsv_pc + STEP;

   bp_stats #(.CNT_W(CNT_W)) u_stats (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_valid  (rsv_valid),
      .hit_right  (rsv_pred == rsv_taken),
      .miss_pulse (mispredict),
      .total_q    (total_cnt),
      .right_q    (correct_cnt)
   );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic [ADDR_W-1:0] fetch_target,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] next_pc,
   input logic              rsv_valid,
   input logic [ADDR_W-1:0] rsv_pc,
   input logic [ADDR_W-1:0] rsv_target,
   input logic              rsv_taken,
   input logic              rsv_pred,
   input logic [ADDR_W-1:0] rsv_next_pc,
   input logic              mispredict,
   input logic [CNT_W-1:0]  total_cnt,
   input logic [CNT_W-1:0]  correct_cnt
);
   assert_next_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> next_pc == fetch_target);
   assert_next_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> next_pc == fetch_pc + ADDR_W'(4));
   assert_static_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> pred_taken == (fetch_target < fetch_pc));
   assert_total_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_valid |=> total_cnt == $past(total_cnt) + 1'b1);
   assert_total_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsv_valid |=> $stable(total_cnt) && $stable(correct_cnt));
   assert_correct_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_valid && rsv_pred == rsv_taken) |=> correct_cnt == $past(correct_cnt) + 1'b1);
   assert_correct_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_valid && rsv_pred != rsv_taken) |=> $stable(correct_cnt));
   assert_miss_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_valid && rsv_pred != rsv_taken) |=> mispredict);
   assert_miss_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsv_valid && rsv_pred != rsv_taken) |=> !mispredict);
endmodule

bind branch_predictor bp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/branch_predictor_test.sv
`timescale 1ns/1ps
module branch_predictor_test;
   localparam int AW = 32;
   localparam int CW = 32;
   localparam int NENT = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [AW-1:0] fetch_pc = '0, fetch_target = '0;
   logic          pred_taken;
   logic [AW-1:0] next_pc;
   logic          rsv_valid = 1'b0;
   logic [AW-1:0] rsv_pc = '0, rsv_target = '0;
   logic          rsv_taken = 1'b0, rsv_pred = 1'b0;
   logic [AW-1:0] rsv_next_pc;
   logic          mispredict;
   logic [CW-1:0] total_cnt, correct_cnt;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   int          tbl [NENT];
   int unsigned m_total, m_correct;
   bit          m_miss;

   always #4 clk = ~clk;

   branch_predictor uut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .fetch_pc(fetch_pc), .fetch_target(fetch_target),
      .pred_taken(pred_taken), .next_pc(next_pc),
      .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_target(rsv_target),
      .rsv_taken(rsv_taken), .rsv_pred(rsv_pred), .rsv_next_pc(rsv_next_pc),
      .mispredict(mispredict), .total_cnt(total_cnt), .correct_cnt(correct_cnt)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int midx(input logic [AW-1:0] pc);
      return int'((pc >> 2) % NENT);
   endfunction

   function automatic bit mguess(input logic [1:0] md, input logic [AW-1:0] pc,
                                 input logic [AW-1:0] tg);
      if (md == 2'd0) return tg < pc;
      return tbl[midx(pc)] >= 2;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NENT; i++) tbl[i] = 1;
      m_total = 0; m_correct = 0; m_miss = 0;
   endtask

   task automatic cyc(input string tag, input logic [1:0] md, input logic [AW-1:0] fpc,
                      input logic [AW-1:0] ftg, input bit rv, input logic [AW-1:0] rpc,
                      input logic [AW-1:0] rtg, input bit rt, input bit rp);
      bit g;
      int k;
      mode = md; fetch_pc = fpc; fetch_target = ftg;
      rsv_valid = rv; rsv_pc = rpc; rsv_target = rtg; rsv_taken = rt; rsv_pred = rp;
      #1;
      g = mguess(md, fpc, ftg);
      check({tag, " guess"}, 64'(pred_taken), 64'(g));
      check("R2 next_pc", 64'(next_pc), 64'(g ? ftg : fpc + 4));
      check("R2 rsv_next_pc", 64'(rsv_next_pc), 64'(rt ? rtg : rpc + 4));
      @(posedge clk);
      m_miss = rv && (rp != rt);
      if (rv) begin
         m_total++;
         if (rp == rt) m_correct++;
         k = midx(rpc);
         if (md == 2'd1) tbl[k] = rt ? 2 : 1;
         else if (md[1]) begin
            if (rt && tbl[k] < 3) tbl[k]++;
            else if (!rt && tbl[k] > 0) tbl[k]--;
         end
      end
      @(negedge clk);
      check("R9 mispredict", 64'(mispredict), 64'(m_miss));
      check("R8 total_cnt", 64'(total_cnt), 64'(m_total));
      check("R8 correct_cnt", 64'(correct_cnt), 64'(m_correct));
   endtask

   task automatic fetch(input string tag, input logic [1:0] md, input logic [AW-1:0] pc);
      cyc(tag, md, pc, pc + 32'h40, 0, 0, 0, 0, 0);
   endtask

   task automatic resolve(input string tag, input logic [1:0] md, input logic [AW-1:0] pc,
                          input bit t, input bit p);
      cyc(tag, md, pc, pc + 32'h40, 1, pc, pc - 32'h20, t, p);
   endtask

   task automatic expect_guess(input string tag, input logic [1:0] md,
                               input logic [AW-1:0] pc, input bit exp);
      mode = md; fetch_pc = pc; fetch_target = pc + 32'h40; rsv_valid = 0;
      #1;
      check(tag, 64'(pred_taken), 64'(exp));
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [AW-1:0] pa, pb, pa2;
      pa = 32'h1000; pb = 32'h1010; pa2 = 32'h1100;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 total", 64'(total_cnt), 0);
      check("R1 correct", 64'(correct_cnt), 0);
      check("R1 mispredict", 64'(mispredict), 0);
      for (int i = 0; i < NENT; i++) fetch("R1", 2'd2, 32'(i * 4));
      for (int i = 0; i < NENT; i += 7) fetch("R1", 2'd1, 32'(i * 4));

      // R3: static direction, equal target, table untouched
      cyc("R3", 2'd0, 32'h2000, 32'h1f00, 0, 0, 0, 0, 0);
      cyc("R3", 2'd0, 32'h2000, 32'h2100, 0, 0, 0, 0, 0);
      cyc("R3", 2'd0, 32'h2000, 32'h2000, 0, 0, 0, 0, 0);
      repeat (3) resolve("R3", 2'd0, pa, 1, 1);
      expect_guess("R3 static leaves table", 2'd2, pa, 0);
      @(negedge clk);

      // R6 R10: training with same-cycle fetch of the same entry
      cyc("R10", 2'd2, pa, pa + 64, 1, pa, pa - 32, 1, 0);
      expect_guess("R10 update visible next cycle", 2'd2, pa, 1);
      @(negedge clk);
      resolve("R6", 2'd2, pa, 1, 1);
      resolve("R6", 2'd2, pa, 1, 1);
      // R7: one not-taken from 11 keeps taken
      resolve("R7", 2'd2, pa, 0, 1);
      expect_guess("R7 hysteresis", 2'd2, pa, 1);
      @(negedge clk);
      resolve("R6", 2'd2, pa, 0, 1);
      expect_guess("R6 down to 01", 2'd3, pa, 0);
      @(negedge clk);
      repeat (3) resolve("R6", 2'd3, pa, 0, 0);
      resolve("R6", 2'd2, pa, 1, 0);
      expect_guess("R6 floor at 00", 2'd2, pa, 0);
      @(negedge clk);

      // R5: one-bit overwrite
      resolve("R5", 2'd1, pb, 1, 0);
      expect_guess("R5 taken stored", 2'd1, pb, 1);
      @(negedge clk);
      resolve("R5", 2'd1, pb, 0, 1);
      expect_guess("R5 not-taken stored", 2'd1, pb, 0);
      @(negedge clk);
      resolve("R5", 2'd1, pb, 1, 0);
      // R11: one-bit write read as counter 10
      expect_guess("R11 mode switch keeps entry", 2'd2, pb, 1);
      @(negedge clk);
      resolve("R11", 2'd2, pb, 0, 1);
      expect_guess("R11 counter from 10 steps to 01", 2'd2, pb, 0);
      @(negedge clk);

      // R4: aliasing across 4*ENTRIES bytes
      resolve("R4", 2'd1, pa2, 1, 0);
      expect_guess("R4 alias shares entry", 2'd1, pa, 1);
      @(negedge clk);

      // random mixed traffic
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] fp, ft, rp2, rt2;
         fp  = {$urandom_range(0, 4095), 2'b00};
         ft  = {$urandom_range(0, 4095), 2'b00};
         rp2 = {$urandom_range(0, 4095), 2'b00};
         rt2 = {$urandom_range(0, 4095), 2'b00};
         cyc("R6 random", 2'($urandom_range(0, 3)), fp, ft, 1'($urandom_range(0, 1)),
             rp2, rt2, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule